// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block sequences a successive-approximation analog-to-digital conversion. Software raises a start request. On the following TAD ticks the sequencer runs an optional automatic acquisition with the sample switch closed. It then opens the switch and runs one setup period, followed by one period per result bit. During those periods it drives a trial code to an external DAC and comparator path and takes back one comparator bit. The search runs from the most significant bit down.

When the last bit is resolved, the sequencer writes the result register, drops its busy bit, raises a sticky interrupt flag and closes the switch. A two-tick discharge wait follows every conversion, whether it completed or was aborted. During that wait a new start is refused. Software aborts a conversion by clearing the start bit, and the stored result is then left untouched. While the sequencer is idle, software may also load the result register directly.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy=0, irq=0, sample_closed=1, trial_code=0 and result=0.
- R2: A start_set pulse raises busy on the next clock. It does so only when en is high in that cycle and was already high in the previous cycle, the sequencer is idle, and busy is low. A start issued in the same cycle as en rises is ignored.
- R3: acq_sel codes 0..7 select 0, 2, 4, 6, 8, 12, 16 or 20 TAD ticks of acquisition, counted from the first tick after start. sample_closed stays 1 through acquisition. With code 0, sample_closed drops to 0 on the first tick.
- R4: sample_closed is 0 for 11 ticks: one setup tick and then one tick per bit. After the setup tick, trial_code is 10'h200.
- R5: On each bit tick the trial bit is kept when cmp_in=1 (input at or above trial_code) and cleared otherwise. The final result equals the input level.
- R6: On the tick that resolves bit 0, result is loaded, busy clears, irq sets and sample_closed returns to 1, all on the same edge.
- R7: start_clr during acquisition or conversion clears busy on the next clock and closes the switch. result and irq are left unchanged. When start_clr and start_set arrive together, busy ends low.
- R8: After a completion or an abort, start_set is ignored for 2 ticks. On the cycle after the second tick, start_set is accepted again.
- R9: The sequencer state does not advance on cycles where tad_tick is low. The conversion result does not depend on how many non-tick cycles separate the ticks.
- R10: wr_res loads wr_data into result only when the sequencer is idle and not busy. It is ignored during conversion and during discharge.
- R11: irq stays set until irq_clr is pulsed. irq_clr clears it on the next clock.
- R12: A synchronous rst during a conversion returns all outputs to the R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Converter enable |
| tad_tick | input | 1 | TAD period enable; the sequence advances only when this is high |
| start_set | input | 1 | Software request to start a conversion |
| start_clr | input | 1 | Software clear of the start bit; aborts an active conversion |
| acq_sel | input | 3 | Acquisition-time code |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above trial_code |
| wr_res | input | 1 | Software write strobe for the result register |
| wr_data | input | NBITS | Data for a software result write |
| irq_clr | input | 1 | Clears the interrupt flag |
| busy | output | 1 | Start/busy bit |
| sample_closed | output | 1 | Sample switch control; 1 connects the holding capacitor |
| trial_code | output | NBITS | Trial code sent to the DAC |
| result | output | NBITS | Result register |
| irq | output | 1 | Conversion-complete interrupt flag |

## Verification
busy responds to start_set and start_clr one clock after the pulse, independent of tad_tick. Every other result is due a fixed number of ticks after the start. The switch opens after 1 + acquisition ticks, trial_code is 10'h200 one tick later, and result, irq and busy change together after 12 + acquisition ticks. The bench drives every input at a falling edge and counts ticks exactly. It samples at the falling edge that follows the rising edge under test, and checks the cycle just before each transition as well as the one on which it is due. In the stall scenario, idle clocks are inserted between ticks, which shows that only the tick count moves the sequence.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tad_tick,
  input  logic             start_set,
  input  logic             start_clr,
  input  logic [2:0]       acq_sel,
  input  logic             cmp_in,
  input  logic             wr_res,
  input  logic [NBITS-1:0] wr_data,
  input  logic             irq_clr,
  output logic             busy,
  output logic             sample_closed,
  output logic [NBITS-1:0] trial_code,
  output logic [NBITS-1:0] result,
  output logic             irq
);
  localparam int IW = $clog2(NBITS);
  localparam int CW = 5;

  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_SETUP, S_BITS, S_DISCH} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [NBITS-1:0] sar;
  logic [NBITS-1:0] sar_upd;
  logic             en_q;

  function automatic logic [CW-1:0] acq_len(input logic [2:0] c);
    case (c)
      3'd0:    acq_len = 5'd0;
      3'd1:    acq_len = 5'd2;
      3'd2:    acq_len = 5'd4;
      3'd3:    acq_len = 5'd6;
      3'd4:    acq_len = 5'd8;
      3'd5:    acq_len = 5'd12;
      3'd6:    acq_len = 5'd16;
      default: acq_len = 5'd20;
    endcase
  endfunction

  wire converting = (state == S_SETUP) || (state == S_BITS);
  wire active     = (state == S_ACQ) || converting;
  wire idle_free  = (state == S_IDLE) && !busy;
  wire start_ok   = start_set && !start_clr && en && en_q && idle_free;
  wire abort      = start_clr && busy && active;
  wire [CW-1:0] acq_n = acq_len(acq_sel);

  assign sample_closed = !converting;
  assign trial_code    = (state == S_BITS) ? sar : '0;

  always_comb begin
    sar_upd      = sar;
    sar_upd[idx] = cmp_in;
    if (idx != '0) sar_upd[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sar    <= '0;
      result <= '0;
      busy   <= 1'b0;
      irq    <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= en;
      if (irq_clr) irq <= 1'b0;
      if (start_clr) busy <= 1'b0;
      else if (start_ok) busy <= 1'b1;
      if (wr_res && idle_free) result <= wr_data;

      if (abort) begin
        state <= S_DISCH;
        cnt   <= 5'd1;
      end else if (tad_tick) begin
        case (state)
          S_IDLE:
            if (busy && !start_clr) begin
              if (acq_n == '0) state <= S_SETUP;
              else begin
                state <= S_ACQ;
                cnt   <= acq_n - 1'b1;
              end
            end
          S_ACQ:
            if (cnt == '0) state <= S_SETUP;
            else cnt <= cnt - 1'b1;
          S_SETUP: begin
            state <= S_BITS;
            idx   <= IW'(NBITS - 1);
            sar   <= {1'b1, {(NBITS-1){1'b0}}};
          end
          S_BITS: begin
            sar <= sar_upd;
            if (idx == '0) begin
              result <= sar_upd;
              busy   <= 1'b0;
              irq    <= 1'b1;
              state  <= S_DISCH;
              cnt    <= 5'd1;
            end else begin
              idx <= idx - 1'b1;
            end
          end
          S_DISCH:
            if (cnt == '0) state <= S_IDLE;
            else cnt <= cnt - 1'b1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    !tad_tick && !start_clr |=> $stable(state));

  p_open_busy_r4: assert property (@(posedge clk) disable iff (rst)
    !sample_closed |-> busy);

  p_done_irq_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(start_clr) && !$past(rst) |-> irq && sample_closed);

  p_result_src_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) && !$past(rst) |-> irq || $past(wr_res));

  p_disch_idle_r8: assert property (@(posedge clk) disable iff (rst)
    state == S_DISCH |-> !busy);

  p_trial_bit_r5: assert property (@(posedge clk) disable iff (rst)
    state == S_BITS |-> trial_code[idx]);
endmodule

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  localparam int TCLK = 10;
  localparam int N    = 10;

  logic clk = 1'b0;
  logic rst, en, tad_tick, start_set, start_clr, wr_res, irq_clr;
  logic [2:0]   acq_sel;
  logic [N-1:0] wr_data, vin;
  logic busy, sample_closed, irq, cmp_in;
  logic [N-1:0] trial_code, result;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  assign cmp_in = (vin >= trial_code);

  sar_seq #(.NBITS(N)) dut (
    .clk(clk), .rst(rst), .en(en), .tad_tick(tad_tick),
    .start_set(start_set), .start_clr(start_clr), .acq_sel(acq_sel),
    .cmp_in(cmp_in), .wr_res(wr_res), .wr_data(wr_data), .irq_clr(irq_clr),
    .busy(busy), .sample_closed(sample_closed), .trial_code(trial_code),
    .result(result), .irq(irq)
  );

  always #(TCLK/2) clk = ~clk;

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t);
    tad_tick = t;
    @(negedge clk);
    tad_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic pulse_start();
    start_set = 1'b1; cyc(1'b0); start_set = 1'b0;
  endtask

  task automatic pulse_clr();
    start_clr = 1'b1; cyc(1'b0); start_clr = 1'b0;
  endtask

  task automatic pulse_irq_clr();
    irq_clr = 1'b1; cyc(1'b0); irq_clr = 1'b0;
  endtask

  task automatic write_res(input logic [N-1:0] d);
    wr_data = d; wr_res = 1'b1; cyc(1'b0); wr_res = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sample_closed", sample_closed, 1);
    chk("R1 trial_code", trial_code, 0);
    chk("R1 result", result, 0);
  endtask

  task automatic t_enable_edge();
    en = 1'b1; start_set = 1'b1; cyc(1'b0); start_set = 1'b0;
    chk("R2 start on enable edge ignored", busy, 0);
    pulse_start();
    chk("R2 start accepted", busy, 1);
    pulse_clr();
    chk("R7 clear cancels pending start", busy, 0);
    ticks(3);
    chk("R7 no conversion after cancel", sample_closed, 1);
    start_set = 1'b1; start_clr = 1'b1; cyc(1'b0);
    start_set = 1'b0; start_clr = 1'b0;
    chk("R7 clear wins over set", busy, 0);
  endtask

  task automatic t_basic(input logic [N-1:0] v);
    pulse_irq_clr();
    vin = v; acq_sel = 3'd0;
    pulse_start();
    chk("R2 busy after start", busy, 1);
    chk("R3 switch closed before first tick", sample_closed, 1);
    cyc(1'b1);
    chk("R3 code 0 opens switch on first tick", sample_closed, 0);
    cyc(1'b1);
    chk("R4 first trial code", trial_code, 10'h200);
    ticks(9);
    chk("R4 busy through 11 ticks", busy, 1);
    chk("R4 switch open through 11 ticks", sample_closed, 0);
    chk("R6 irq not yet", irq, 0);
    cyc(1'b1);
    chk("R6 busy cleared", busy, 0);
    chk("R6 irq set", irq, 1);
    chk("R6 switch closed", sample_closed, 1);
    chk("R5 result", result, v);
    pulse_start();
    chk("R8 start ignored right after completion", busy, 0);
    ticks(2);
  endtask

  task automatic t_acq(input logic [2:0] code, input int len, input logic [N-1:0] v);
    vin = v; acq_sel = code;
    pulse_start();
    ticks(len);
    chk("R3 switch closed through acquisition", sample_closed, 1);
    chk("R3 busy during acquisition", busy, 1);
    cyc(1'b1);
    chk("R3 switch opens after acquisition", sample_closed, 0);
    ticks(10);
    chk("R3 busy before last bit", busy, 1);
    cyc(1'b1);
    chk("R3 done after acquisition plus 12", busy, 0);
    chk("R5 result with acquisition", result, v);
    ticks(2);
  endtask

  task automatic t_stall();
    vin = 10'h155; acq_sel = 3'd0;
    pulse_start();
    for (int i = 0; i < 11; i++) begin
      for (int k = 0; k < 3; k++) cyc(1'b0);
      cyc(1'b1);
    end
    for (int k = 0; k < 5; k++) cyc(1'b0);
    chk("R9 no advance without tick", busy, 1);
    cyc(1'b1);
    chk("R9 done on 12th tick", busy, 0);
    chk("R9 result with stalls", result, 10'h155);
    ticks(2);
  endtask

  task automatic t_abort();
    write_res(10'h0AB);
    chk("R10 idle write", result, 10'h0AB);
    pulse_irq_clr();
    vin = 10'h3C3; acq_sel = 3'd0;
    pulse_start();
    ticks(5);
    write_res(10'h111);
    chk("R10 write ignored while busy", result, 10'h0AB);
    pulse_clr();
    chk("R7 busy cleared by abort", busy, 0);
    chk("R7 switch closed by abort", sample_closed, 1);
    chk("R7 result kept", result, 10'h0AB);
    chk("R7 irq not set", irq, 0);
    write_res(10'h222);
    chk("R10 write ignored in discharge", result, 10'h0AB);
    pulse_start();
    chk("R8 start ignored in discharge", busy, 0);
    cyc(1'b1);
    pulse_start();
    chk("R8 start ignored after one tick", busy, 0);
    cyc(1'b1);
    pulse_start();
    chk("R8 start accepted after two ticks", busy, 1);
    pulse_clr();
  endtask

  task automatic t_irq();
    t_basic(10'h0F0);
    for (int k = 0; k < 6; k++) cyc(1'b0);
    chk("R11 irq sticky", irq, 1);
    pulse_irq_clr();
    chk("R11 irq cleared", irq, 0);
  endtask

  task automatic t_midreset();
    vin = 10'h2AA; acq_sel = 3'd0;
    pulse_start();
    ticks(4);
    rst = 1'b1; cyc(1'b0); rst = 1'b0;
    chk("R12 busy after reset", busy, 0);
    chk("R12 switch after reset", sample_closed, 1);
    chk("R12 result after reset", result, 0);
    chk("R12 irq after reset", irq, 0);
    chk("R12 trial after reset", trial_code, 0);
    cyc(1'b0);
    t_basic(10'h2AA);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; tad_tick = 1'b0; start_set = 1'b0; start_clr = 1'b0;
    wr_res = 1'b0; irq_clr = 1'b0; acq_sel = 3'd0; wr_data = '0; vin = '0;
    @(negedge clk);
    cyc(1'b0);
    rst = 1'b0;
    cyc(1'b0);
    t_reset();
    t_enable_edge();
    t_basic(10'h2A5);
    t_basic(10'h000);
    t_basic(10'h3FF);
    t_basic(10'h200);
    t_basic(10'h1FF);
    t_acq(3'd2, 4, 10'h0C7);
    t_acq(3'd5, 12, 10'h301);
    t_acq(3'd7, 20, 10'h05A);
    t_stall();
    t_abort();
    t_irq();
    t_midreset();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule